// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a four-wire serial link that fills and reads back a small bank of 8-bit configuration registers. The host drives a serial clock, a data input and an active-low select, and it samples a data output. Each transaction is 16 bits long and travels least-significant bit first in both directions. The first eight bits form a header: a direction flag, a register address and three spare bits. The last eight bits carry the data. On a write, the host supplies the data byte. On a read, the block shifts the addressed register out during that second byte.

The serial pins are sampled by a faster system clock through synchronizer flops, and serial clock edges are found in the system clock domain. Two framing styles are supported. In the first, the serial clock may run freely and the select line brackets each transaction. In the second, the select line is tied low, the serial clock toggles only during transfers and idles low, and the internal bit counter alone separates frames by wrapping after every 16 bits. A frame may arrive as one continuous word or as two bytes with an idle-clock pause between them.

Top module: `cfg_serial_port`

## Requirements
- R1: Input bits are captured on rising serial clock edges, least-significant frame bit first, so the first bit sent is frame bit 0.
- R2: Frame bit 0 is the direction flag (0 = write, 1 = read), bits 4:1 are the register address, and bits 15:8 are the data byte, with bit 8 being its LSB.
- R3: A write changes the addressed register only after the 16th rising edge of the frame. After 15 edges, the register still holds its old value.
- R4: On a read, the output carries data bit k from a falling serial clock edge until the next falling edge, valid across the rising edge of frame bit 8+k. The read leaves the register unchanged.
- R5: While select is high, serial clock edges are ignored, no register changes, and the data output is 0.
- R6: Select rising before the 16th edge discards the partial frame without a write, and the next frame starts again at bit 0.
- R7: With select held low, the bit counter wraps after 16 bits, so back-to-back frames are separated by count alone.
- R8: A frame sent as two 8-bit bytes, with the serial clock idle low between them, acts exactly like one continuous 16-bit word.
- R9: After reset, every register reads 0 and the data output is 0.
- R10: Frame bits 7:5 are spare and have no effect on any write or read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_csn | input | 1 | Active-low select for the serial port |
| ser_dout | output | 1 | Serial read data; 0 when not shifting read data |
| cfg_regs | output | NREG*8 | All configuration registers, register i in bits 8*i+7:8*i |

## Verification
The assertions assume the serial pins change slowly compared with the system clock, so every serial clock level lasts several system cycles and each edge is seen exactly once after synchronization. They also assume select changes only while the serial clock is low, so a select edge never looks like a clock edge. The stimulus keeps every serial half-period at ten system cycles and moves select only after the clock has returned low. It also waits several system cycles after each frame before reading the register outputs.

// File: rtl/csp_pkg.sv
// Package: shared frame layout constants for the serial configuration port.
// Assumes a fixed 16-bit frame: 8-bit header followed by 8-bit data byte.
package csp_pkg;
    localparam int FRAME_W  = 16;
    localparam int HDR_W    = 8;
    localparam int DATA_W   = FRAME_W - HDR_W;
    localparam int ADDR_W   = 4;
    localparam int RW_BIT   = 0;
    localparam int ADDR_LSB = 1;
    localparam int HDR_USED = ADDR_LSB + ADDR_W;   // bits above are spare
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int BSEL_W   = $clog2(DATA_W);
endpackage

// File: rtl/csp_sync.sv
// Module: brings the serial pins into the system clock domain and flags
// serial clock edges. Assumes each serial level lasts several clk cycles.
// All three pins pass through the same number of stages so they stay aligned.
module csp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic ser_csn,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s,
    output logic cs_act
);
    logic [STAGES-1:0] clk_chain;
    logic [STAGES-1:0] din_chain;
    logic [STAGES-1:0] csn_chain;
    logic              clk_last;

    // Synchronizer chains; select resets to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_chain <= '0;
            din_chain <= '0;
            csn_chain <= '1;
        end else begin
            clk_chain <= {clk_chain[STAGES-2:0], ser_clk};
            din_chain <= {din_chain[STAGES-2:0], ser_din};
            csn_chain <= {csn_chain[STAGES-2:0], ser_csn};
        end
    end

    // Previous synchronized serial clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_last <= 1'b0;
        else        clk_last <= clk_chain[STAGES-1];
    end

    // Edge flags and clean pin values.
    always_comb begin
        sclk_rise = clk_chain[STAGES-1] & ~clk_last;
        sclk_fall = ~clk_chain[STAGES-1] & clk_last;
        din_s     = din_chain[STAGES-1];
        cs_act    = ~csn_chain[STAGES-1];
    end
endmodule

// File: rtl/csp_frame.sv
// Module: counts serial bits, collects header and data LSB first, issues a
// one-cycle write pulse on the 16th rising edge of a write frame, and shifts
// read data out on falling edges during the second byte.
// Assumes edge flags from csp_sync; counter wraps every FRAME_W bits.
module csp_frame
    import csp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic              cs_act,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout
);
    logic [CNT_W-1:0]    cnt;
    logic [HDR_USED-1:0] hdr;
    logic [DATA_W-2:0]   dat;
    logic                dout_q;
    logic                in_data;
    logic                last_bit;
    logic [BSEL_W-1:0]   bsel;

    // Position decode of the current bit.
    always_comb begin
        in_data  = (cnt >= CNT_W'(HDR_W));
        last_bit = (cnt == CNT_W'(FRAME_W - 1));
        bsel     = cnt[BSEL_W-1:0];
    end

    // Bit counter: held at 0 while deselected, wraps after a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!cs_act)           cnt <= '0;
        else if (sclk_rise)         cnt <= cnt + CNT_W'(1);
    end

    // Header capture; spare header bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr <= '0;
        end else if (cs_act && sclk_rise) begin
            for (int k = 0; k < HDR_USED; k++)
                if (cnt == CNT_W'(k)) hdr[k] <= din_s;
        end
    end

    // Data capture of the first DATA_W-1 data bits; the last comes live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat <= '0;
        end else if (cs_act && sclk_rise) begin
            for (int k = 0; k < DATA_W - 1; k++)
                if (cnt == CNT_W'(HDR_W + k)) dat[k] <= din_s;
        end
    end

    // Read shifter: new bit on each falling edge of the data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)              dout_q <= 1'b0;
        else if (!cs_act)        dout_q <= 1'b0;
        else if (sclk_fall)      dout_q <= (in_data && hdr[RW_BIT]) ? rd_data[bsel] : 1'b0;
    end

    // Write request and decoded fields toward the bank.
    always_comb begin
        wr_en   = cs_act && sclk_rise && last_bit && !hdr[RW_BIT];
        addr    = hdr[ADDR_LSB +: ADDR_W];
        wr_data = {din_s, dat};
        dout    = dout_q;
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (cnt == '0));                                        // R5
    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !dout_q);                                            // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sclk_rise) |=> (cnt == $past(cnt) + CNT_W'(1)));      // R7
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sclk_fall) |=> $stable(dout_q));                     // R4
    AST_WR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt == CNT_W'(FRAME_W - 1)));                         // R3
endmodule

// File: rtl/csp_regbank.sv
// Module: bank of NREG configuration registers with one registered write
// port and one combinational read port. Addresses at or above NREG write
// nothing and read as zero.
module csp_regbank
    import csp_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // One register: loads on a write to its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 regs_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))       regs_q[i] <= wr_data;
        end

        assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];

        AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(i)) |=> (regs_flat[i*DATA_W +: DATA_W] == $past(wr_data))); // R3
    end

    // Read mux over the populated addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (addr == ADDR_W'(i)) rd_data = regs_q[i];
    end

    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));                                  // R5
endmodule

// File: rtl/cfg_serial_port.sv
// Module: top of the serial configuration port. Connects the pin
// synchronizer, the frame controller and the register bank.
// Assumes clk runs several times faster than ser_clk and that ser_csn only
// changes while ser_clk is low.
module cfg_serial_port
    import csp_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   ser_csn,
    output logic                   ser_dout,
    output logic [NREG*DATA_W-1:0] cfg_regs
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              din_s;
    logic              cs_act;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    csp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_csn   (ser_csn),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .cs_act    (cs_act)
    );

    csp_frame frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .cs_act    (cs_act),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .dout      (ser_dout)
    );

    csp_regbank #(.NREG(NREG)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );
endmodule

// File: tb/cfg_serial_port_tb_top.sv
module cfg_serial_port_tb_top;
    localparam int NREG = 16;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_din = 1'b0;
    logic ser_csn = 1'b1;
    logic ser_dout;
    logic [NREG*8-1:0] cfg_regs;

    int errors = 0;
    int checks = 0;
    logic tied_low = 1'b0;
    logic [7:0] model [NREG];

    always #2 clk = ~clk;

    cfg_serial_port #(.NREG(NREG)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_csn  (ser_csn),
        .ser_dout (ser_dout),
        .cfg_regs (cfg_regs)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One serial bit; got is ser_dout just before the rising edge.
    task automatic xfer_bit(input logic b, output logic got);
        ser_din = b;
        wait_clk(HALF);
        got = ser_dout;
        ser_clk = 1'b1;
        wait_clk(HALF);
        ser_clk = 1'b0;
    endtask

    // Full frame; split inserts an idle-clock gap after the header byte.
    task automatic frame(input logic rd, input logic [3:0] a, input logic [7:0] d,
                         input logic [2:0] spare, input logic split, output logic [7:0] q);
        logic [15:0] w;
        logic got;
        w = {d, spare, a, rd};
        q = '0;
        if (!tied_low) begin ser_csn = 1'b0; wait_clk(HALF); end
        for (int i = 0; i < 16; i++) begin
            if (split && i == 8) wait_clk(6 * HALF);
            xfer_bit(w[i], got);
            if (i >= 8) q[i-8] = got;
        end
        wait_clk(HALF);
        if (!tied_low) ser_csn = 1'b1;
        wait_clk(HALF);
    endtask

    function automatic logic [7:0] reg_of(input int i);
        return cfg_regs[i*8 +: 8];
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < NREG; i++)
            check(reg_of(i) == model[i], req, reg_of(i), model[i]);
    endtask

    task automatic t_reset;
        check(ser_dout == 1'b0, "R9 dout", ser_dout, 0);
        check(cfg_regs == '0, "R9 regs", cfg_regs[31:0], 0);
    endtask

    task automatic t_word_write;
        logic [7:0] q;
        frame(1'b0, 4'd3, 8'hA5, 3'b000, 1'b0, q);
        model[3] = 8'hA5;
        check(reg_of(3) == 8'hA5, "R1 R2 word write", reg_of(3), 8'hA5);
        check_all("R2 other regs");
    endtask

    task automatic t_commit_timing;
        logic [15:0] w;
        logic got;
        w = {8'h6B, 3'b000, 4'd4, 1'b0};
        ser_csn = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 15; i++) xfer_bit(w[i], got);
        wait_clk(HALF);
        check(reg_of(4) == 8'h00, "R3 before 16th edge", reg_of(4), 0);
        xfer_bit(w[15], got);
        wait_clk(HALF);
        check(reg_of(4) == 8'h6B, "R3 after 16th edge", reg_of(4), 8'h6B);
        model[4] = 8'h6B;
        ser_csn = 1'b1; wait_clk(HALF);
    endtask

    task automatic t_split_write;
        logic [7:0] q;
        frame(1'b0, 4'd7, 8'h3C, 3'b000, 1'b1, q);
        model[7] = 8'h3C;
        check(reg_of(7) == 8'h3C, "R8 split write", reg_of(7), 8'h3C);
    endtask

    task automatic t_read;
        logic [7:0] q;
        frame(1'b1, 4'd3, 8'hFF, 3'b000, 1'b0, q);
        check(q == 8'hA5, "R4 read data", q, 8'hA5);
        check(reg_of(3) == 8'hA5, "R4 read keeps reg", reg_of(3), 8'hA5);
        frame(1'b1, 4'd7, 8'h00, 3'b000, 1'b1, q);
        check(q == 8'h3C, "R8 split read", q, 8'h3C);
        check(ser_dout == 1'b0, "R5 dout after deselect", ser_dout, 0);
    endtask

    task automatic t_spare_bits;
        logic [7:0] q;
        frame(1'b0, 4'd5, 8'h81, 3'b111, 1'b0, q);
        model[5] = 8'h81;
        check(reg_of(5) == 8'h81, "R10 spare bits write", reg_of(5), 8'h81);
        frame(1'b1, 4'd5, 8'h00, 3'b101, 1'b0, q);
        check(q == 8'h81, "R10 spare bits read", q, 8'h81);
        check_all("R10 no side writes");
    endtask

    task automatic t_abort;
        logic [15:0] w;
        logic got;
        logic [7:0] q;
        w = {8'hFF, 3'b000, 4'd9, 1'b0};
        ser_csn = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 10; i++) xfer_bit(w[i], got);
        wait_clk(HALF);
        ser_csn = 1'b1; wait_clk(2 * HALF);
        check(reg_of(9) == 8'h00, "R6 partial frame dropped", reg_of(9), 0);
        frame(1'b0, 4'd9, 8'h12, 3'b000, 1'b0, q);
        model[9] = 8'h12;
        check(reg_of(9) == 8'h12, "R6 restart at bit 0", reg_of(9), 8'h12);
        check_all("R6 bank");
    endtask

    task automatic t_clocks_deselected;
        logic got;
        logic bad = 1'b0;
        ser_csn = 1'b1;
        for (int i = 0; i < 20; i++) begin
            xfer_bit(1'b1, got);
            if (got !== 1'b0) bad = 1'b1;
        end
        wait_clk(HALF);
        check(!bad, "R5 dout while deselected", bad, 0);
        check_all("R5 clocks ignored");
        frame(1'b0, 4'd10, 8'h55, 3'b000, 1'b0, got_byte);
        model[10] = 8'h55;
        check(reg_of(10) == 8'h55, "R5 counter unmoved", reg_of(10), 8'h55);
    endtask

    logic [7:0] got_byte;

    task automatic t_tied_low;
        logic [7:0] q;
        tied_low = 1'b1;
        ser_csn = 1'b0;
        wait_clk(HALF);
        frame(1'b0, 4'd1, 8'h11, 3'b000, 1'b0, q);
        frame(1'b0, 4'd2, 8'h22, 3'b000, 1'b1, q);
        frame(1'b1, 4'd1, 8'h00, 3'b000, 1'b0, q);
        model[1] = 8'h11;
        model[2] = 8'h22;
        check(q == 8'h11, "R7 read in tied mode", q, 8'h11);
        check(reg_of(2) == 8'h22, "R7 back-to-back write", reg_of(2), 8'h22);
        check_all("R7 bank");
        ser_csn = 1'b1;
        tied_low = 1'b0;
        wait_clk(HALF);
    endtask

    logic done = 1'b0;

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_word_write();
        t_commit_timing();
        t_split_write();
        t_read();
        t_spare_bits();
        t_abort();
        t_clocks_deselected();
        t_tied_low();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule